// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes a stream of digitised RGB pixels, one per pixel clock with a valid strobe, and presents them on one or two output ports. With the two-port mode off, every pixel goes to port A and port B is switched off through its output-enable. With the two-port mode on, successive pixels are steered alternately to A and B. Two timings are then available. In the interleaved timing each port updates on its own slot. In the paired timing the first pixel of a pair is held back, and both ports then update together with a single data strobe.

All outputs are registered, so a pixel accepted at one clock edge appears on the ports after that edge. The data-clock strobe marks every cycle in which the external receiver should latch. Any change of either mode input restarts the A/B slot sequence at port A, so a receiver never sees half a pair across a mode switch.

Top module: `pix_port_demux`

## Requirements
- R1: With `dual_en` = 0, each cycle with `pix_vld` = 1 loads the pixel onto `porta_q` and pulses `dclk_stb` for one cycle, both visible after the capturing clock edge.
- R2: `portb_oe` equals the value `dual_en` had at the previous clock edge. While `dual_en` = 0, `portb_q` keeps its value.
- R3: With `dual_en` = 1 and `pair_mode` = 0, valid pixels go alternately to `porta_q` and `portb_q`, the first to port A. Each such update pulses `dclk_stb`.
- R4: With `dual_en` = 1 and `pair_mode` = 1, the first pixel of a pair is held internally, with no strobe and no port change. The second pixel loads `portb_q`, and the held pixel loads `porta_q` in the same cycle, with one `dclk_stb` pulse.
- R5: While `dual_en` = 0, the value of `pair_mode` has no effect on the outputs.
- R6: A cycle in which {`dual_en`,`pair_mode`} differs from its value at the previous edge treats its pixel as the first of a sequence (slot A). Any pixel held for pairing is discarded.
- R7: A cycle with `pix_vld` = 0 leaves both ports unchanged and produces no `dclk_stb` pulse.
- R8: During reset, `porta_q` and `portb_q` are 0, `portb_oe` is 1 and `dclk_stb` is 0. The remembered mode resets to two-port paired (dual 1, pair 1) and the slot resets to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel valid strobe |
| pix_data | input | 24 | Pixel, three 8-bit channels |
| dual_en | input | 1 | 1 = two-port steering, 0 = port A only |
| pair_mode | input | 1 | 1 = paired timing, 0 = interleaved (two-port only) |
| porta_q | output | 24 | Port A pixel |
| portb_q | output | 24 | Port B pixel |
| portb_oe | output | 1 | Port B output-enable, 0 = tri-state |
| dclk_stb | output | 1 | Data-clock strobe, one cycle per port update event |

## Verification
The properties assume that the mode inputs are synchronous to the pixel clock and settle before the edge that samples them. They also assume that `pix_vld` and `pix_data` are driven to known values, never X, after reset. The stimulus changes every input only on the falling clock edge, well away from the capturing edge. It switches modes mid-sequence on purpose, including with a pixel held for pairing, so that the restart rule sees both a clean boundary and an abandoned pair.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
   typedef enum logic {
      SLOT_A = 1'b0,
      SLOT_B = 1'b1
   } slot_e;

   typedef struct packed {
      logic dual;
      logic pair;
   } mode_t;
endpackage

// File: rtl/pdm_slot_ctrl.sv
module pdm_slot_ctrl
   import pix_demux_pkg::*;
#(
   parameter bit RST_DUAL = 1'b1,
   parameter bit RST_PAIR = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pix_vld,
   input  logic  dual_en,
   input  logic  pair_mode,
   output slot_e slot_now,
   output logic  mode_chg
);
   mode_t mode_q;
   mode_t mode_in;
   slot_e slot_q;

   assign mode_in  = '{dual: dual_en, pair: pair_mode};
   assign mode_chg = (mode_in != mode_q);
   assign slot_now = mode_chg ? SLOT_A : slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '{dual: RST_DUAL, pair: RST_PAIR};
         slot_q <= SLOT_A;
      end else begin
         mode_q <= mode_in;
         if (dual_en && pix_vld)
            slot_q <= (slot_now == SLOT_A) ? SLOT_B : SLOT_A;
         else if (mode_chg || !dual_en)
            slot_q <= SLOT_A;
      end
   end

   // R6: a mode change always restarts the sequence at slot A
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && dual_en && pix_vld) |=> (slot_q == SLOT_B));
endmodule

// File: rtl/pdm_pair_hold.sv
module pdm_pair_hold #(
   parameter int CH_W = 8,
   parameter int NCH  = 3,
   localparam int PIX_W = CH_W * NCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] held_q
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CH_W-1:0] ch_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ch_q <= '0;
         else if (load)
            ch_q <= pix_in[c*CH_W +: CH_W];
      end
      assign held_q[c*CH_W +: CH_W] = ch_q;
   end

   // R4: the held pixel only changes when a first-of-pair is loaded
   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(held_q));
endmodule

// File: rtl/pix_port_demux.sv
module pix_port_demux
   import pix_demux_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter int NCH      = 3,
   parameter bit RST_DUAL = 1'b1,
   parameter bit RST_PAIR = 1'b1,
   localparam int PIX_W   = CH_W * NCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_vld,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             dual_en,
   input  logic             pair_mode,
   output logic [PIX_W-1:0] porta_q,
   output logic [PIX_W-1:0] portb_q,
   output logic             portb_oe,
   output logic             dclk_stb
);
   if (CH_W < 1) begin : g_bad_width
      $error("pix_port_demux: CH_W must be at least 1");
   end
   if (NCH < 1) begin : g_bad_count
      $error("pix_port_demux: NCH must be at least 1");
   end

   slot_e            slot_now;
   logic             mode_chg;
   logic [PIX_W-1:0] held_q;
   logic             take_a;
   logic             take_b;
   logic             pair_ld;
   logic             pair_fire;

   pdm_slot_ctrl #(
      .RST_DUAL (RST_DUAL),
      .RST_PAIR (RST_PAIR)
   ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_vld   (pix_vld),
      .dual_en   (dual_en),
      .pair_mode (pair_mode),
      .slot_now  (slot_now),
      .mode_chg  (mode_chg)
   );

   pdm_pair_hold #(
      .CH_W (CH_W),
      .NCH  (NCH)
   ) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (pair_ld),
      .pix_in (pix_data),
      .held_q (held_q)
   );

   always_comb begin
      take_a    = pix_vld && (!dual_en || (!pair_mode && slot_now == SLOT_A));
      take_b    = pix_vld && dual_en && !pair_mode && (slot_now == SLOT_B);
      pair_ld   = pix_vld && dual_en && pair_mode && (slot_now == SLOT_A);
      pair_fire = pix_vld && dual_en && pair_mode && (slot_now == SLOT_B);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         porta_q  <= '0;
         portb_q  <= '0;
         portb_oe <= RST_DUAL;
         dclk_stb <= 1'b0;
      end else begin
         portb_oe <= dual_en;
         dclk_stb <= take_a || take_b || pair_fire;
         if (take_a)
            porta_q <= pix_data;
         else if (pair_fire)
            porta_q <= held_q;
         if (take_b || pair_fire)
            portb_q <= pix_data;
      end
   end

   // R2: output-enable tracks the two-port mode one cycle later
   p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (portb_oe == $past(dual_en)));
   // R2: port B frozen in single-port mode
   p_b_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_en |=> $stable(portb_q));
   // R7: no strobe and no port change without a valid pixel
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |=> (!dclk_stb && $stable(porta_q) && $stable(portb_q)));
   // R1: single-port pixel lands on port A with a strobe
   p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual_en && pix_vld) |=> (dclk_stb && porta_q == $past(pix_data)));
   // R4: first of a pair produces no strobe
   p_pair_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_en && pair_mode && pix_vld && slot_now == SLOT_A) |=> !dclk_stb);
   // R4: second of a pair updates port B and strobes
   p_pair_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_en && pair_mode && pix_vld && slot_now == SLOT_B)
      |=> (dclk_stb && portb_q == $past(pix_data)));
endmodule

// File: tb/pix_port_demux_tb_top.sv
module pix_port_demux_tb_top;
   localparam int PIX_W = 24;
   localparam int NROW  = 15;

   typedef struct packed {
      logic [3:0]       req;
      logic             vld;
      logic             dual;
      logic             pair;
      logic [PIX_W-1:0] data;
      logic [PIX_W-1:0] exp_a;
      logic [PIX_W-1:0] exp_b;
      logic             exp_oe;
      logic             exp_stb;
   } row_t;

   localparam row_t ROWS [NROW] = '{
      '{4'd6, 1'b1, 1'b1, 1'b0, 24'h111111, 24'h111111, 24'h000000, 1'b1, 1'b1},
      '{4'd3, 1'b1, 1'b1, 1'b0, 24'h222222, 24'h111111, 24'h222222, 1'b1, 1'b1},
      '{4'd7, 1'b0, 1'b1, 1'b0, 24'h333333, 24'h111111, 24'h222222, 1'b1, 1'b0},
      '{4'd3, 1'b1, 1'b1, 1'b0, 24'h444444, 24'h444444, 24'h222222, 1'b1, 1'b1},
      '{4'd1, 1'b1, 1'b0, 1'b0, 24'h555555, 24'h555555, 24'h222222, 1'b0, 1'b1},
      '{4'd1, 1'b1, 1'b0, 1'b0, 24'h666666, 24'h666666, 24'h222222, 1'b0, 1'b1},
      '{4'd5, 1'b1, 1'b0, 1'b1, 24'h777777, 24'h777777, 24'h222222, 1'b0, 1'b1},
      '{4'd4, 1'b1, 1'b1, 1'b1, 24'h888888, 24'h777777, 24'h222222, 1'b1, 1'b0},
      '{4'd7, 1'b0, 1'b1, 1'b1, 24'h999999, 24'h777777, 24'h222222, 1'b1, 1'b0},
      '{4'd4, 1'b1, 1'b1, 1'b1, 24'hAAAAAA, 24'h888888, 24'hAAAAAA, 1'b1, 1'b1},
      '{4'd4, 1'b1, 1'b1, 1'b1, 24'hBBBBBB, 24'h888888, 24'hAAAAAA, 1'b1, 1'b0},
      '{4'd4, 1'b1, 1'b1, 1'b1, 24'hCCCCCC, 24'hBBBBBB, 24'hCCCCCC, 1'b1, 1'b1},
      '{4'd4, 1'b1, 1'b1, 1'b1, 24'hDDDDDD, 24'hBBBBBB, 24'hCCCCCC, 1'b1, 1'b0},
      '{4'd6, 1'b1, 1'b1, 1'b0, 24'hEEEEEE, 24'hEEEEEE, 24'hCCCCCC, 1'b1, 1'b1},
      '{4'd3, 1'b1, 1'b1, 1'b0, 24'hF0F0F0, 24'hEEEEEE, 24'hF0F0F0, 1'b1, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             pix_vld;
   logic [PIX_W-1:0] pix_data;
   logic             dual_en;
   logic             pair_mode;
   logic [PIX_W-1:0] porta_q;
   logic [PIX_W-1:0] portb_q;
   logic             portb_oe;
   logic             dclk_stb;
   int               n_chk  = 0;
   int               n_fail = 0;
   bit               done   = 1'b0;

   always #2.5 clk = ~clk;

   pix_port_demux dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_vld   (pix_vld),
      .pix_data  (pix_data),
      .dual_en   (dual_en),
      .pair_mode (pair_mode),
      .porta_q   (porta_q),
      .portb_q   (portb_q),
      .portb_oe  (portb_oe),
      .dclk_stb  (dclk_stb)
   );

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic d, input logic p,
                        input logic [PIX_W-1:0] x);
      @(negedge clk);
      pix_vld = v; dual_en = d; pair_mode = p; pix_data = x;
      @(posedge clk);
      #1;
   endtask

   task automatic check_reset_state;
      chk("R8", "porta", porta_q, '0);
      chk("R8", "portb", portb_q, '0);
      chk("R8", "oe",    {23'd0, portb_oe}, 24'd1);
      chk("R8", "stb",   {23'd0, dclk_stb}, 24'd0);
   endtask

   initial begin
      rst_n = 1'b0; pix_vld = 1'b0; dual_en = 1'b1; pair_mode = 1'b1;
      pix_data = '0;
      repeat (3) @(posedge clk);
      #1;
      check_reset_state();
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         drive(ROWS[i].vld, ROWS[i].dual, ROWS[i].pair, ROWS[i].data);
         chk(tag(ROWS[i].req), "porta", porta_q, ROWS[i].exp_a);
         chk(tag(ROWS[i].req), "portb", portb_q, ROWS[i].exp_b);
         chk("R2", "oe",  {23'd0, portb_oe}, {23'd0, ROWS[i].exp_oe});
         chk(tag(ROWS[i].req), "stb", {23'd0, dclk_stb}, {23'd0, ROWS[i].exp_stb});
      end

      // R8: reset in the middle of a pair discards the held pixel
      drive(1'b1, 1'b1, 1'b1, 24'h123456);
      @(negedge clk);
      rst_n = 1'b0; pix_vld = 1'b0;
      @(posedge clk);
      #1;
      check_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      // R8: slot restarts at A, so this pixel starts a fresh pair
      drive(1'b1, 1'b1, 1'b1, 24'hABCDEF);
      chk("R8", "stb after reset first", {23'd0, dclk_stb}, 24'd0);
      drive(1'b1, 1'b1, 1'b1, 24'h0F0F0F);
      chk("R4", "pair A after reset", porta_q, 24'hABCDEF);
      chk("R4", "pair B after reset", portb_q, 24'h0F0F0F);
      chk("R4", "pair stb", {23'd0, dclk_stb}, 24'd1);

      // R5: pair bit toggled while single-port, outputs as in plain single mode
      drive(1'b1, 1'b0, 1'b1, 24'h010203);
      drive(1'b1, 1'b0, 1'b0, 24'h040506);
      chk("R5", "single A", porta_q, 24'h040506);
      chk("R5", "single stb", {23'd0, dclk_stb}, 24'd1);
      chk("R5", "single B held", portb_q, 24'h0F0F0F);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule